// File: doc/BRIEF.md
# Shared Interrupt Request Concentrator

The concentrator takes 64 level-sensitive interrupt inputs and turns them into a single outstanding request, shown as one asserted line on a 64-line output bank. Inputs 0 to 31 belong to expansion-slot devices. They are gated in groups of four, with one mapping register per group. Inputs 32 to 63 belong to on-board devices, and each has a mapping register of its own. Every mapping register has an enable bit and a fixed identification value that software can read.

While no request is outstanding, the lowest-numbered input that is both pending and enabled wins. The winning request then stays on its output line until software acknowledges it. It acknowledges either by writing a clear register or by disabling the request's mapping entry. Either action re-runs arbitration in the same cycle. Software reaches the block through a 32-bit register port with single-cycle read and write strobes. Read data appears one cycle after the strobe.

Top module: `irq_concentrator`

## Requirements
- R1: After reset no output line is asserted, every enable bit is 0, and every input's pending state is cleared.
- R2: A mapping register reads with its enable in bit 31 and a fixed identification in bits 30:0. Slot group g reads 0x7C0 + 4g. On-board entry j reads 0x7E0 + j. Writes change only bit 31.
- R3: Slot group g (0..7) has its mapping register at byte offset 0xC04 + 8g. It gates inputs 4g to 4g+3.
- R4: On-board entry j (0..31) has its mapping register at 0x1004 + 8j. It gates input 32 + j.
- R5: At most one output line is high at any time. Line k high means request k is outstanding.
- R6: Suppose an input goes high at clock edge t and no request is outstanding. Its request appears after edge t+1. When several eligible inputs are pending, the lowest-numbered one wins.
- R7: An outstanding request stays unchanged when its input drops, when a lower-numbered input becomes eligible, or when other mapping registers are written.
- R8: A write to the slot clear register at 0x1404 + 32g acknowledges the outstanding request only if the request number divided by 4 equals g. A write with any other g has no effect.
- R9: A write to the on-board clear register at 0x1804 + 8j acknowledges the outstanding request only if that request is 32 + j.
- R10: An acknowledge drops the line and arbitrates again in the same edge. An input that is still eligible therefore shows right after the acknowledging write.
- R11: Writing bit 31 = 0 to the mapping entry of the outstanding request withdraws that request and re-arbitrates at once. Disabling any other entry leaves the request unchanged.
- R12: A pending input whose mapping entry is disabled never issues. Enabling the entry lets it issue right after the enabling write.
- R13: These offsets read zero and ignore writes: any offset with bit 2 clear, and any offset outside the map and clear windows. Two read-only bus-error entries at 0x1104 and 0x110C read 0x7F0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Level interrupt inputs; bits 31:0 slot lines, 63:32 on-board lines |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_addr | input | 16 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| req_out | output | 64 | One-hot outstanding request, all zero when none |

## Verification
The block has no tunable parameters, so the bench builds it at its fixed size: 64 inputs, 8 slot groups and 32 on-board entries. At this size the bench can reach both ends of each address window, such as group 7 and on-board entry 31. It can also reach the seam between slot input 31 and on-board input 32. The directed scenarios pit a slot input against an on-board input of higher number, and they acknowledge through a correct and a wrong clear register. They also withdraw a request by disabling its entry while another input waits. This shows whether the same-edge re-arbitration picks the expected successor.

// File: rtl/irq_concentrator.sv
module irq_concentrator (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] irq_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] req_out
);
  localparam int N_IN   = 64;
  localparam int N_GRP  = 8;
  localparam int N_BRD  = 32;
  localparam int GRP_SZ = (N_IN - N_BRD) / N_GRP;

  localparam logic [30:0] ID_SLOT = 31'h7C0;
  localparam logic [30:0] ID_BRD  = 31'h7E0;
  localparam logic [30:0] ID_BERR = 31'h7F0;

  logic [N_GRP-1:0] grp_en, grp_en_nxt;
  logic [N_BRD-1:0] brd_en, brd_en_nxt;
  logic [N_IN-1:0]  pending, en_vec, elig;
  logic             req_valid;
  logic [5:0]       req_num, win_num;
  logic             any_elig;

  wire       data_half = reg_addr[2];
  wire       sel_gmap  = (reg_addr[15:6] == 10'h030);
  wire       sel_bmap  = (reg_addr[15:8] == 8'h10);
  wire       sel_berr  = (reg_addr[15:4] == 12'h110);
  wire       sel_gclr  = (reg_addr[15:8] == 8'h14);
  wire       sel_bclr  = (reg_addr[15:8] == 8'h18);
  wire       wr_ok     = reg_wr & data_half;
  wire [2:0] gmap_idx  = reg_addr[5:3];
  wire [4:0] bmap_idx  = reg_addr[7:3];
  wire [2:0] gclr_idx  = reg_addr[7:5];

  always_comb begin
    grp_en_nxt = grp_en;
    brd_en_nxt = brd_en;
    if (wr_ok && sel_gmap) grp_en_nxt[gmap_idx] = reg_wdata[31];
    if (wr_ok && sel_bmap) brd_en_nxt[bmap_idx] = reg_wdata[31];
  end

  always_comb begin
    for (int i = 0; i < N_IN - N_BRD; i++) en_vec[i] = grp_en_nxt[i / GRP_SZ];
    for (int j = 0; j < N_BRD; j++) en_vec[N_IN - N_BRD + j] = brd_en_nxt[j];
  end

  assign elig     = pending & en_vec;
  assign any_elig = |elig;

  always_comb begin
    win_num = '0;
    for (int k = N_IN - 1; k >= 0; k--)
      if (elig[k]) win_num = 6'(k);
  end

  wire req_is_slot = ~req_num[5];
  wire ack_hit = req_valid & wr_ok &
                 ((sel_gclr & req_is_slot & (req_num[4:2] == gclr_idx)) |
                  (sel_bclr & ~req_is_slot & (req_num[4:0] == bmap_idx)));
  wire drop_hit = req_valid & wr_ok & ~reg_wdata[31] &
                  ((sel_gmap & req_is_slot & (req_num[4:2] == gmap_idx)) |
                   (sel_bmap & ~req_is_slot & (req_num[4:0] == bmap_idx)));
  wire keep = req_valid & ~ack_hit & ~drop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en    <= '0;
      brd_en    <= '0;
      pending   <= '0;
      req_valid <= 1'b0;
      req_num   <= '0;
    end else begin
      grp_en  <= grp_en_nxt;
      brd_en  <= brd_en_nxt;
      pending <= irq_in;
      if (!keep) begin
        req_valid <= any_elig;
        req_num   <= any_elig ? win_num : '0;
      end
    end
  end

  assign req_out = req_valid ? (64'd1 << req_num) : '0;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (data_half) begin
      if (sel_gmap)      rd_val = {grp_en[gmap_idx], ID_SLOT + {26'd0, gmap_idx, 2'b00}};
      else if (sel_bmap) rd_val = {brd_en[bmap_idx], ID_BRD + {26'd0, bmap_idx}};
      else if (sel_berr && !reg_addr[3] || sel_berr && reg_addr[3]) rd_val = {1'b0, ID_BERR};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] irq_in,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic [63:0] req_out
);
  a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_out));

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_out == '0));

  a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out != '0 && !reg_wr) |=> (req_out == $past(req_out)));

  a_r6_request_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out != '0 && $past(req_out) == '0 && $past(rst_n, 2)) |->
      ((req_out & $past(irq_in, 2)) != '0));

  a_r13_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_addr[2]) |=> (reg_rdata == '0));
endmodule

bind irq_concentrator irq_concentrator_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .req_out(req_out)
);

// File: tb/irq_concentrator_tb_top.sv
`timescale 1ns/1ps
module irq_concentrator_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] req_out;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_concentrator dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_out(req_out)
  );

  function automatic logic [63:0] oh(int n);
    return 64'd1 << n;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; irq_in = '0;
    edges(2);
    rst_n = 1;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset();
    chk("R1 idle output", req_out, '0);
    rd(16'h0C04, d); chk("R1 group0 enable clear", d, 32'h7C0);
    irq_in = oh(3); edges(3);
    chk("R1 pending only after enable", req_out, '0);
  endtask

  task automatic t_maps;
    logic [31:0] d;
    do_reset();
    rd(16'h0C3C, d); chk("R2 group7 id", d, 32'h7DC);
    wr(16'h0C0C, 32'hFFFF_FFFF);
    rd(16'h0C0C, d); chk("R2 R3 group1 write keeps id", d, 32'h8000_07C4);
    rd(16'h1024, d); chk("R4 board4 id", d, 32'h7E4);
    wr(16'h10FC, 32'h8000_0000);
    rd(16'h10FC, d); chk("R4 board31 enabled", d, 32'h8000_07FF);
    rd(16'h1104, d); chk("R13 bus error map 0", d, 32'h7F0);
    rd(16'h110C, d); chk("R13 bus error map 1", d, 32'h7F0);
    rd(16'h0C08, d); chk("R13 low half zero", d, 32'h0);
    wr(16'h0C00, 32'h8000_0000);
    rd(16'h0C04, d); chk("R13 low half write ignored", d, 32'h7C0);
    wr(16'h2004, 32'hFFFF_FFFF);
    rd(16'h2004, d); chk("R13 unmapped reads zero", d, 32'h0);
    chk("R13 unmapped write no request", req_out, '0);
  endtask

  task automatic t_priority_and_clear;
    do_reset();
    wr(16'h0C0C, 32'h8000_0000);
    wr(16'h101C, 32'h8000_0000);
    irq_in = oh(5) | oh(35);
    edges(1); chk("R6 not yet after one edge", req_out, '0);
    edges(1); chk("R6 R5 lowest wins", req_out, oh(5));
    irq_in = oh(4) | oh(35); edges(3);
    chk("R7 held despite drop and lower input", req_out, oh(5));
    wr(16'h1404, 32'h0);
    chk("R8 wrong group clear ignored", req_out, oh(5));
    wr(16'h1424, 32'h0);
    chk("R8 R10 ack picks next at once", req_out, oh(4));
    irq_in = oh(35); edges(2);
    wr(16'h1424, 32'h0);
    chk("R10 ack moves to board line", req_out, oh(35));
    wr(16'h1824, 32'h0);
    chk("R9 wrong board clear ignored", req_out, oh(35));
    irq_in = '0; edges(2);
    wr(16'h181C, 32'h0);
    chk("R9 board clear drops request", req_out, '0);
  endtask

  task automatic t_withdraw;
    do_reset();
    wr(16'h0C04, 32'h8000_0000);
    irq_in = oh(2) | oh(9); edges(2);
    chk("R12 disabled input does not win", req_out, oh(2));
    wr(16'h0C14, 32'h0);
    chk("R11 other disable no effect", req_out, oh(2));
    wr(16'h0C14, 32'h8000_0000);
    chk("R7 other enable no effect", req_out, oh(2));
    wr(16'h0C04, 32'h0);
    chk("R11 withdraw and re-arbitrate", req_out, oh(9));
  endtask

  task automatic t_late_enable;
    do_reset();
    irq_in = oh(40) | oh(63); edges(3);
    chk("R12 disabled pending stays quiet", req_out, '0);
    wr(16'h10FC, 32'h8000_0000);
    chk("R12 enable issues next edge", req_out, oh(63));
    wr(16'h1044, 32'h8000_0000);
    chk("R7 higher enable keeps request", req_out, oh(63));
    wr(16'h10FC, 32'h0);
    chk("R11 board withdraw", req_out, oh(40));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_maps();
        t_priority_and_clear();
        t_withdraw();
        t_late_enable();
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule